// File: doc/BRIEF.md
# Line-Fill Buffer With Recency Tracking

This block holds the single cache line that is being brought in from external memory. A miss allocates the buffer to a new line address. Longword beats then arrive one at a time, each tagged with its position in the line, in any order, including critical-word-first wrap order. Each beat sets a per-longword valid bit, and lookups are answered straight from the buffer as soon as the requested longword has landed.

One recency flag decides which copy of the buffered set location is newer: the buffer or the cache array entry. An allocation sets the flag. An access that falls on the same array set but belongs to a different line clears it, because that access made the array entry the more recent one. When the next miss arrives, the old line is offered to the array through a write-back request only if it is complete, still marked as newer, and came from a cacheable fill. The new line is not loaded until that request has been taken.

A mode input lets non-cacheable instruction fetches use the buffer as a staging area. Such lines can serve hits but are never offered to the array. A second mode input narrows the set index from seven bits to six for the split array arrangement.

Top module: `fill_line_buffer`

## Requirements
- R1: A synchronous reset, or a one-cycle pulse on `inval_i`, clears all valid bits, the recency flag and the non-cacheable marker, and withdraws any pending write-back. After it, no lookup hits and fill beats are ignored until the next accepted miss.
- R2: An accepted miss with no write-back due loads the buffer at the next clock edge. The buffer takes line address `miss_line_i` (byte address bits [31:4]), clears all four valid bits and sets the recency flag. A miss is accepted when `miss_cache_i`=1, or when `miss_instr_i`=1 and `ncbuf_en_i`=1.
- R3: A beat with `fill_valid_i`=1 writes `fill_data_i` into longword `fill_off_i` (byte address bits [3:2]) and sets that longword's valid bit, in any arrival order. Beats arriving while no line is allocated, or while a write-back is pending, are ignored.
- R4: `lk_hit_o` is 1 in the same cycle as a lookup only when `lk_valid_i`=1, `lk_addr_i` bits [29:2] equal the buffered line address, and the valid bit for `lk_addr_i` bits [1:0] is set. `lk_data_o` then returns that longword.
- R5: The buffer's set index is byte address bits [10:4] when `split_i`=0. When `split_i`=1 it is bits [9:4], and bit 6 of `wb_set_o` reads 0. `wb_tag_o` carries byte address bits [31:10].
- R6: A lookup whose set index equals the buffer's set index but whose line address differs clears the recency flag. A lookup to the buffered line itself leaves the flag unchanged.
- R7: On an accepted miss, a write-back is requested only if all four valid bits are set, the recency flag is set, and the line was not loaded by a non-cacheable fetch. Otherwise the old line is dropped and the new line loads at once.
- R8: `wb_valid_o` and `busy_o` are 1 from the cycle after the triggering miss until a cycle with `wb_ready_i`=1. During this time `wb_set_o`, `wb_tag_o` and `wb_data_o` are stable, with longword k at bits [32k+31:32k]. New misses are ignored. At the handshake edge the pending line is loaded as in R2.
- R9: With `ncbuf_en_i`=1, a non-cacheable instruction miss loads the buffer, and later lookups can hit that line, but it is never offered for write-back. With `ncbuf_en_i`=0, or for a non-cacheable data miss, the miss leaves the buffer untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inval_i | input | 1 | Invalidate the buffer |
| split_i | input | 1 | 1 selects the six-bit set index |
| ncbuf_en_i | input | 1 | Allow non-cacheable instruction lines into the buffer |
| miss_i | input | 1 | Miss strobe |
| miss_line_i | input | 28 | Line address of the miss |
| miss_cache_i | input | 1 | Miss is cacheable |
| miss_instr_i | input | 1 | Miss is an instruction fetch |
| fill_valid_i | input | 1 | Fill beat present |
| fill_off_i | input | 2 | Longword position of the beat |
| fill_data_i | input | 32 | Beat data |
| lk_valid_i | input | 1 | Lookup present |
| lk_addr_i | input | 30 | Lookup longword address |
| lk_hit_o | output | 1 | Lookup hits in the buffer |
| lk_data_o | output | 32 | Longword returned on a hit |
| busy_o | output | 1 | Write-back pending, misses ignored |
| wb_valid_o | output | 1 | Write-back request |
| wb_ready_i | input | 1 | Array accepts the write-back |
| wb_set_o | output | 7 | Set index of the offered line |
| wb_tag_o | output | 22 | Tag of the offered line |
| wb_data_o | output | 128 | The four longwords of the offered line |

## Verification
The write-back decision is tried with the line in four states:
- complete and untouched;
- complete but displaced by a same-set lookup to another line;
- complete after a lookup to the line itself;
- one longword short.

These states separate the recency rule from the completeness rule. The same displacement lookup is issued under both set-index widths. It leaves the flag alone with seven bits and clears it with six, which shows which address bits the comparison uses. Non-cacheable misses are tried with buffering disabled, as data fetches, and as instruction fetches with buffering enabled. Afterwards the old line's hits and the absence of a later write-back show which of these cases took the buffer. Fills arrive in wrapped order, and stray beats and misses are sent while a write-back is stalled.

// File: rtl/lfb_pkg.sv
package lfb_pkg;

    localparam int ADDR_W   = 32;
    localparam int DATA_W   = 32;
    localparam int WORDS    = 4;
    localparam int SET_W    = 7;
    localparam int OFF_W    = $clog2(WORDS);
    localparam int LW_W     = ADDR_W - 2;
    localparam int LINE_W   = LW_W - OFF_W;
    localparam int TAG_W    = LINE_W - SET_W + 1;

    typedef logic [LINE_W-1:0]  line_t;
    typedef logic [SET_W-1:0]   set_t;
    typedef logic [OFF_W-1:0]   off_t;
    typedef logic [DATA_W-1:0]  word_t;
    typedef logic [LW_W-1:0]    lw_addr_t;
    typedef logic [WORDS-1:0][DATA_W-1:0] line_data_t;

    typedef enum logic {
        CTL_RUN = 1'b0,
        CTL_WB  = 1'b1
    } ctl_e;

    typedef struct packed {
        logic              live;
        logic              nc;
        line_t             line;
        logic [WORDS-1:0]  vld;
    } buf_state_t;

    // Set index of a line; the narrow mode drops the top index bit.
    function automatic set_t set_of(line_t l, logic narrow);
        set_t s;
        s = l[SET_W-1:0];
        if (narrow) s[SET_W-1] = 1'b0;
        return s;
    endfunction

    function automatic line_t line_of(lw_addr_t a);
        return a[LW_W-1:OFF_W];
    endfunction

    function automatic off_t word_of(lw_addr_t a);
        return a[OFF_W-1:0];
    endfunction

endpackage

// File: rtl/lfb_store.sv
module lfb_store
    import lfb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       load,
    input  line_t      load_line,
    input  logic       load_nc,
    input  logic       fill_we,
    input  off_t       fill_off,
    input  word_t      fill_data,
    output buf_state_t st_o,
    output line_data_t words_o
);

    buf_state_t st_q;
    line_data_t words_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q <= '0;
        end else if (load) begin
            st_q.live <= 1'b1;
            st_q.nc   <= load_nc;
            st_q.line <= load_line;
            st_q.vld  <= '0;
        end else if (fill_we) begin
            st_q.vld[fill_off] <= 1'b1;
        end
    end

    for (genvar k = 0; k < WORDS; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (fill_we && (fill_off == off_t'(k))) begin
                words_q[k] <= fill_data;
            end
        end
    end

    assign st_o    = st_q;
    assign words_o = words_q;

endmodule

// File: rtl/lfb_lookup.sv
module lfb_lookup
    import lfb_pkg::*;
(
    input  logic             lk_valid,
    input  lw_addr_t         lk_addr,
    input  logic             narrow,
    input  logic             live,
    input  line_t            line,
    input  logic [WORDS-1:0] vld,
    input  line_data_t       words,
    output logic             hit,
    output word_t            data,
    output logic             touch,
    output set_t             buf_set
);

    line_t lk_line;
    off_t  lk_off;
    logic  same_line;
    logic  same_set;

    always_comb begin
        lk_line   = line_of(lk_addr);
        lk_off    = word_of(lk_addr);
        buf_set   = set_of(line, narrow);
        same_line = live && (lk_line == line);
        same_set  = live && (set_of(lk_line, narrow) == buf_set);
        hit       = lk_valid && same_line && vld[lk_off];
        data      = words[lk_off];
        touch     = lk_valid && same_set && !same_line;
    end

endmodule

// File: rtl/lfb_ctrl.sv
module lfb_ctrl
    import lfb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  logic  ncbuf_en,
    input  logic  miss,
    input  line_t miss_line,
    input  logic  miss_cache,
    input  logic  miss_instr,
    input  logic  wb_ready,
    input  logic  live,
    input  logic  full,
    input  logic  nc,
    input  logic  touch,
    output logic  load,
    output line_t load_line,
    output logic  load_nc,
    output logic  wb_valid,
    output logic  mru
);

    ctl_e  st_q;
    logic  mru_q;
    line_t pend_line_q;
    logic  pend_nc_q;
    logic  take;
    logic  due;

    always_comb begin
        take      = miss && (st_q == CTL_RUN) &&
                    (miss_cache || (miss_instr && ncbuf_en));
        due       = live && full && mru_q && !nc;
        load      = (take && !due) || ((st_q == CTL_WB) && wb_ready);
        load_line = (st_q == CTL_WB) ? pend_line_q : miss_line;
        load_nc   = (st_q == CTL_WB) ? pend_nc_q   : !miss_cache;
        wb_valid  = (st_q == CTL_WB);
        mru       = mru_q;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            st_q        <= CTL_RUN;
            pend_line_q <= '0;
            pend_nc_q   <= 1'b0;
        end else begin
            case (st_q)
                CTL_RUN: if (take && due) begin
                    st_q        <= CTL_WB;
                    pend_line_q <= miss_line;
                    pend_nc_q   <= !miss_cache;
                end
                CTL_WB: if (wb_ready) st_q <= CTL_RUN;
                default: st_q <= CTL_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr)  mru_q <= 1'b0;
        else if (load)   mru_q <= 1'b1;
        else if (touch)  mru_q <= 1'b0;
    end

endmodule

// File: rtl/fill_line_buffer.sv
module fill_line_buffer
    import lfb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              inval_i,
    input  logic              split_i,
    input  logic              ncbuf_en_i,
    input  logic              miss_i,
    input  logic [LINE_W-1:0] miss_line_i,
    input  logic              miss_cache_i,
    input  logic              miss_instr_i,
    input  logic              fill_valid_i,
    input  logic [OFF_W-1:0]  fill_off_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic              lk_valid_i,
    input  logic [LW_W-1:0]   lk_addr_i,
    output logic              lk_hit_o,
    output logic [DATA_W-1:0] lk_data_o,
    output logic              busy_o,
    output logic              wb_valid_o,
    input  logic              wb_ready_i,
    output logic [SET_W-1:0]  wb_set_o,
    output logic [TAG_W-1:0]  wb_tag_o,
    output logic [WORDS*DATA_W-1:0] wb_data_o
);

    buf_state_t line_st;
    line_data_t words;
    logic       load;
    line_t      load_line;
    logic       load_nc;
    logic       touch;
    logic       mru_q;
    logic       wb_pend;
    logic       fill_we;
    set_t       buf_set;
    logic [WORDS-1:0] vld_w;
    logic       nc_w;

    assign fill_we = fill_valid_i && line_st.live && !wb_pend;
    assign vld_w   = line_st.vld;
    assign nc_w    = line_st.nc;

    lfb_store u_store (
        .clk       (clk),
        .rst       (rst),
        .clr       (inval_i),
        .load      (load),
        .load_line (load_line),
        .load_nc   (load_nc),
        .fill_we   (fill_we),
        .fill_off  (fill_off_i),
        .fill_data (fill_data_i),
        .st_o      (line_st),
        .words_o   (words)
    );

    lfb_lookup u_lookup (
        .lk_valid (lk_valid_i),
        .lk_addr  (lk_addr_i),
        .narrow   (split_i),
        .live     (line_st.live),
        .line     (line_st.line),
        .vld      (line_st.vld),
        .words    (words),
        .hit      (lk_hit_o),
        .data     (lk_data_o),
        .touch    (touch),
        .buf_set  (buf_set)
    );

    lfb_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .clr        (inval_i),
        .ncbuf_en   (ncbuf_en_i),
        .miss       (miss_i),
        .miss_line  (miss_line_i),
        .miss_cache (miss_cache_i),
        .miss_instr (miss_instr_i),
        .wb_ready   (wb_ready_i),
        .live       (line_st.live),
        .full       (&line_st.vld),
        .nc         (line_st.nc),
        .touch      (touch),
        .load       (load),
        .load_line  (load_line),
        .load_nc    (load_nc),
        .wb_valid   (wb_pend),
        .mru        (mru_q)
    );

    assign busy_o     = wb_pend;
    assign wb_valid_o = wb_pend;
    assign wb_set_o   = buf_set;
    assign wb_tag_o   = line_st.line[LINE_W-1:SET_W-1];
    assign wb_data_o  = words;

endmodule

// File: rtl/fill_line_buffer_chk.sv
module fill_line_buffer_chk
    import lfb_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              inval_i,
    input logic              lk_valid_i,
    input logic              lk_hit_o,
    input logic              wb_valid_o,
    input logic              wb_ready_i,
    input logic [SET_W-1:0]  wb_set_o,
    input logic [TAG_W-1:0]  wb_tag_o,
    input logic [WORDS*DATA_W-1:0] wb_data_o,
    input logic [WORDS-1:0]  vld,
    input logic              nc,
    input logic              mru
);

    p_clear_r1: assert property (@(posedge clk) disable iff (rst)
        inval_i |=> (!wb_valid_o && (vld == '0) && !mru && !nc));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (wb_valid_o && wb_ready_i && !inval_i) |=> (mru && (vld == '0) && !wb_valid_o));

    p_hit_r4: assert property (@(posedge clk) disable iff (rst)
        lk_hit_o |-> (lk_valid_i && (vld != '0)));

    p_full_r7: assert property (@(posedge clk) disable iff (rst)
        wb_valid_o |-> ((&vld) && mru));

    p_nc_r9: assert property (@(posedge clk) disable iff (rst)
        nc |-> !wb_valid_o);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (wb_valid_o && !wb_ready_i && !inval_i) |=>
            (wb_valid_o && $stable(wb_data_o) && $stable(wb_set_o) && $stable(wb_tag_o)));

endmodule

bind fill_line_buffer fill_line_buffer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .inval_i    (inval_i),
    .lk_valid_i (lk_valid_i),
    .lk_hit_o   (lk_hit_o),
    .wb_valid_o (wb_valid_o),
    .wb_ready_i (wb_ready_i),
    .wb_set_o   (wb_set_o),
    .wb_tag_o   (wb_tag_o),
    .wb_data_o  (wb_data_o),
    .vld        (vld_w),
    .nc         (nc_w),
    .mru        (mru_q)
);

// File: tb/fill_line_buffer_test.sv
`timescale 1ns/1ps
module fill_line_buffer_test;
    import lfb_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst = 1'b1, inval_i = 0, split_i = 0, ncbuf_en_i = 0;
    logic miss_i = 0, miss_cache_i = 0, miss_instr_i = 0;
    logic [LINE_W-1:0] miss_line_i = '0;
    logic fill_valid_i = 0;
    logic [OFF_W-1:0] fill_off_i = '0;
    logic [DATA_W-1:0] fill_data_i = '0;
    logic lk_valid_i = 0;
    logic [LW_W-1:0] lk_addr_i = '0;
    logic lk_hit_o, busy_o, wb_valid_o, wb_ready_i = 0;
    logic [DATA_W-1:0] lk_data_o;
    logic [SET_W-1:0] wb_set_o;
    logic [TAG_W-1:0] wb_tag_o;
    logic [WORDS*DATA_W-1:0] wb_data_o;

    fill_line_buffer uut (.*);

    int n_chk = 0;
    int n_bad = 0;

    function automatic logic [31:0] dat(logic [31:0] a);
        return 32'hC35A_0000 ^ {a[15:0], a[15:0]} ^ a;
    endfunction

    typedef struct packed {
        logic [31:0] addr;
        logic        hit;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{32'h0000_1230, 1'b1, 32'hC35A_0000 ^ 32'h1230_1230 ^ 32'h0000_1230},
        '{32'h0000_1234, 1'b1, 32'hC35A_0000 ^ 32'h1234_1234 ^ 32'h0000_1234},
        '{32'h0000_1238, 1'b1, 32'hC35A_0000 ^ 32'h1238_1238 ^ 32'h0000_1238},
        '{32'h0000_123C, 1'b1, 32'hC35A_0000 ^ 32'h123C_123C ^ 32'h0000_123C},
        '{32'h0000_1240, 1'b0, 32'h0},
        '{32'h0000_5244, 1'b0, 32'h0}
    };

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_miss(logic [31:0] a, logic c, logic ins);
        miss_i = 1; miss_line_i = a[31:4]; miss_cache_i = c; miss_instr_i = ins;
        tick();
        miss_i = 0;
    endtask

    task automatic fill(logic [31:0] a);
        fill_valid_i = 1; fill_off_i = a[3:2]; fill_data_i = dat(a);
        tick();
        fill_valid_i = 0;
    endtask

    task automatic fill_line(logic [31:0] a);
        for (int k = 0; k < 4; k++) begin
            logic [1:0] w;
            w = a[3:2] + 2'(k);
            fill({a[31:4], w, 2'b00});
        end
    endtask

    task automatic look(logic [31:0] a, logic eh, logic [31:0] ed, string req);
        lk_valid_i = 1; lk_addr_i = a[31:2];
        #1;
        chk(req, lk_hit_o, eh);
        if (eh) chk(req, lk_data_o, ed);
        tick();
        lk_valid_i = 0;
    endtask

    task automatic wb_check(logic [6:0] s, logic [21:0] t, logic [31:0] b, string req);
        chk(req, wb_valid_o, 1'b1);
        chk(req, busy_o, 1'b1);
        chk(req, wb_set_o, s);
        chk(req, wb_tag_o, t);
        chk(req, wb_data_o, {dat(b + 12), dat(b + 8), dat(b + 4), dat(b)});
    endtask

    task automatic handshake();
        wb_ready_i = 1;
        tick();
        wb_ready_i = 0;
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        tick(); tick();
        rst = 0;
        // R1 reset state
        chk("R1", busy_o, 1'b0);
        chk("R1", wb_valid_o, 1'b0);
        look(32'h1230, 0, 0, "R1");

        // R2 allocate, R3 wrapped fill
        do_miss(32'h1238, 1, 1);
        chk("R7", wb_valid_o, 1'b0);
        look(32'h1238, 0, 0, "R2");
        fill(32'h1238);
        look(32'h1238, 1, dat(32'h1238), "R3");
        look(32'h123C, 0, 0, "R4");
        fill(32'h123C); fill(32'h1230); fill(32'h1234);
        for (int i = 0; i < 6; i++) look(VEC[i].addr, VEC[i].hit, VEC[i].data, "R4");

        // R7/R8 write-back with stall
        do_miss(32'h4560, 1, 0);
        wb_check(7'h23, 22'h4, 32'h1230, "R7");
        fill(32'h4560);
        do_miss(32'h7770, 1, 1);
        wb_check(7'h23, 22'h4, 32'h1230, "R8");
        handshake();
        chk("R8", wb_valid_o, 1'b0);
        chk("R8", busy_o, 1'b0);
        look(32'h4560, 0, 0, "R3");
        look(32'h1230, 0, 0, "R8");
        fill(32'h4560);
        look(32'h4560, 1, dat(32'h4560), "R8");
        look(32'h7770, 0, 0, "R8");

        // R6 displacement clears recency
        fill(32'h4564); fill(32'h4568); fill(32'h456C);
        look(32'h0560, 0, 0, "R6");
        do_miss(32'h8350, 1, 0);
        chk("R6", wb_valid_o, 1'b0);
        look(32'h4560, 0, 0, "R7");

        // R6 same-line access keeps recency
        fill_line(32'h8354);
        look(32'h8354, 1, dat(32'h8354), "R6");
        do_miss(32'h9990, 1, 0);
        wb_check(7'h35, 22'h20, 32'h8350, "R6");
        handshake();

        // R7 incomplete line dropped
        fill(32'h9990); fill(32'h9994); fill(32'h9998);
        do_miss(32'h0770, 1, 0);
        chk("R7", wb_valid_o, 1'b0);

        // R5 wide index
        fill_line(32'h0770);
        look(32'h0370, 0, 0, "R5");
        do_miss(32'h1B70, 1, 0);
        wb_check(7'h77, 22'h1, 32'h0770, "R5");
        handshake();

        // R5 narrow index
        split_i = 1;
        fill_line(32'h1B7C);
        do_miss(32'h2F70, 1, 0);
        wb_check(7'h37, 22'h6, 32'h1B70, "R5");
        handshake();
        fill_line(32'h2F70);
        look(32'h0370, 0, 0, "R5");
        do_miss(32'h5000, 1, 0);
        chk("R5", wb_valid_o, 1'b0);
        split_i = 0;

        // R9 non-cacheable handling
        fill_line(32'h5000);
        do_miss(32'h6000, 0, 1);
        chk("R9", busy_o, 1'b0);
        look(32'h5000, 1, dat(32'h5000), "R9");
        ncbuf_en_i = 1;
        do_miss(32'h6000, 0, 0);
        chk("R9", busy_o, 1'b0);
        look(32'h5004, 1, dat(32'h5004), "R9");
        do_miss(32'h6000, 0, 1);
        wb_check(7'h00, 22'h14, 32'h5000, "R9");
        handshake();
        fill_line(32'h6008);
        look(32'h6008, 1, dat(32'h6008), "R9");
        do_miss(32'h7000, 1, 0);
        chk("R9", wb_valid_o, 1'b0);
        look(32'h6000, 0, 0, "R9");
        ncbuf_en_i = 0;

        // R1 invalidate
        fill_line(32'h7000);
        look(32'h700C, 1, dat(32'h700C), "R1");
        inval_i = 1; tick(); inval_i = 0;
        look(32'h700C, 0, 0, "R1");
        fill(32'h7000);
        look(32'h7000, 0, 0, "R1");
        do_miss(32'h7100, 1, 0);
        fill_line(32'h7100);
        do_miss(32'h7200, 1, 0);
        chk("R1", wb_valid_o, 1'b1);
        inval_i = 1; tick(); inval_i = 0;
        chk("R1", wb_valid_o, 1'b0);
        chk("R1", busy_o, 1'b0);

        summary();
        $finish;
    end

endmodule